// File: doc/BRIEF.md
# GPIO Bank with Event Detection

This block is a memory-mapped general-purpose I/O controller for 54 pins. The pins are grouped into two 32-bit banks. Bank 1 holds only 22 live pins. Software uses a simple synchronous register port to choose a 3-bit function code for each pin and to raise or lower output latches. The outputs are driven through write-only set and clear words, so no read-modify-write is needed. Software reads the synchronized pin levels from the same port.

Each pin has four detector enables: rising edge, falling edge, high level and low level. Any enabled condition sets a sticky status bit, and software clears that bit by writing a one to it. Each bank drives its own interrupt line, which stays high while any status bit in that bank is set. Pin inputs cross into the clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

Top module: `gpio_event_bank`

## Requirements
- R1: The 3-bit function code of pin p sits in function word p/10, at bit (p%10)*3. The function words are at byte addresses 0x00 to 0x14, and the codes read back as written. Code 1 means output, and pinOe for a pin is high only when its code is 1 (codes 0 and 2 to 7 give pinOe low).
- R2: Writing to the set word (0x1C for bank 0, 0x20 for bank 1) drives pinOut high for every pin whose bit is 1. Bits written as 0 leave those pins unchanged. Pin p maps to bank p/32, bit p%32.
- R3: Writing to the clear word (0x28 for bank 0, 0x2C for bank 1) drives pinOut low for every pin whose bit is 1. Bits written as 0 leave those pins unchanged.
- R4: A read of the level word (0x34 for bank 0, 0x38 for bank 1) returns pinIn after a two-flop synchronizer.
- R5: When the rising-edge enable is set (0x4C for bank 0, 0x50 for bank 1), a synchronized 0-to-1 change sets the pin's status bit. When the enable is clear, no status bit is set.
- R6: When the falling-edge enable is set (0x58 for bank 0, 0x5C for bank 1), a 1-to-0 change sets the status bit. With both edge enables set, either edge sets it.
- R7: While the high-level enable (0x64/0x68) is set and the pin is high, or the low-level enable (0x70/0x74) is set and the pin is low, the status bit keeps being set. It therefore reappears after a clear until the level changes.
- R8: The status words (0x40 for bank 0, 0x44 for bank 1) clear each bit written as 1 and ignore bits written as 0. If a clear and a new event reach the same bit in the same cycle, the bit stays set.
- R9: irqBank[b] is high exactly while any status bit of bank b is set.
- R10: After reset, every register reads 0, pinOut and pinOe are 0, and both interrupt lines are low.
- R11: Reads of the set and clear words and of unmapped addresses return 0. The bits for pins 54 to 63 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe; data appears on busRdData after the next edge |
| busRdData | output | 32 | Registered read data |
| pinIn | input | 54 | Asynchronous pin levels |
| pinOut | output | 54 | Output latches |
| pinOe | output | 54 | Output enable, high when the function code is 1 |
| irqBank | output | 2 | Per-bank interrupt |

## Verification
A status bit set by mistake shows on the bank interrupt in the cycle after the faulty update. It also shows in a status read two edges later. A wrong bank or bit mapping makes a pin respond through the other bank's word, which a read of both words exposes. A synchronizer or edge-history fault shifts or loses events by a cycle, so status is checked a fixed number of edges after each pin change. A broken write-one-to-clear is exposed by checking that a level-held bit comes back at once after a clear and stays cleared once the level has gone.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int FSEL_IDX_W = 3;
  localparam logic [2:0] FN_OUTPUT = 3'd1;

  typedef enum logic [2:0] {
    RD_NONE, RD_FSEL, RD_LEVEL, RD_STATUS, RD_RISE, RD_FALL, RD_HIGH, RD_LOW
  } rdSel_e;

  typedef struct packed {
    logic                  fselWe;
    logic [FSEL_IDX_W-1:0] fselIdx;
    logic                  setWe;
    logic                  clrWe;
    logic                  statWe;
    logic                  riseWe;
    logic                  fallWe;
    logic                  highWe;
    logic                  lowWe;
    logic                  bank;
    rdSel_e                rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output strobe_t           strb
);
  localparam int NUM_FSEL   = (NUM_PINS + 9) / 10;
  localparam int BASE_SET   = 7;
  localparam int BASE_CLR   = 10;
  localparam int BASE_LEV   = 13;
  localparam int BASE_STAT  = 16;
  localparam int BASE_RISE  = 19;
  localparam int BASE_FALL  = 22;
  localparam int BASE_HIGH  = 25;
  localparam int BASE_LOW   = 28;

  logic unusedAddrBits;
  assign unusedAddrBits = &{1'b0, busAddr[1:0]};

  int wordIdx;

  function automatic logic hitPair(input int w, input int base);
    return (w == base) || (w == base + 1);
  endfunction

  always_comb begin
    wordIdx = int'(busAddr[ADDR_W-1:2]);
    strb = '0;
    strb.rdSel = RD_NONE;
    if (wordIdx < NUM_FSEL) begin
      strb.rdSel   = RD_FSEL;
      strb.fselIdx = FSEL_IDX_W'(wordIdx);
      strb.fselWe  = busWr;
    end else if (hitPair(wordIdx, BASE_SET)) begin
      strb.bank  = (wordIdx == BASE_SET + 1);
      strb.setWe = busWr;
    end else if (hitPair(wordIdx, BASE_CLR)) begin
      strb.bank  = (wordIdx == BASE_CLR + 1);
      strb.clrWe = busWr;
    end else if (hitPair(wordIdx, BASE_LEV)) begin
      strb.bank  = (wordIdx == BASE_LEV + 1);
      strb.rdSel = RD_LEVEL;
    end else if (hitPair(wordIdx, BASE_STAT)) begin
      strb.bank   = (wordIdx == BASE_STAT + 1);
      strb.rdSel  = RD_STATUS;
      strb.statWe = busWr;
    end else if (hitPair(wordIdx, BASE_RISE)) begin
      strb.bank   = (wordIdx == BASE_RISE + 1);
      strb.rdSel  = RD_RISE;
      strb.riseWe = busWr;
    end else if (hitPair(wordIdx, BASE_FALL)) begin
      strb.bank   = (wordIdx == BASE_FALL + 1);
      strb.rdSel  = RD_FALL;
      strb.fallWe = busWr;
    end else if (hitPair(wordIdx, BASE_HIGH)) begin
      strb.bank   = (wordIdx == BASE_HIGH + 1);
      strb.rdSel  = RD_HIGH;
      strb.highWe = busWr;
    end else if (hitPair(wordIdx, BASE_LOW)) begin
      strb.bank  = (wordIdx == BASE_LOW + 1);
      strb.rdSel = RD_LOW;
      strb.lowWe = busWr;
    end
  end
endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 busRd,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_PINS-1:0]  pinOut,
  output logic [NUM_PINS-1:0]  pinOe,
  output logic [(NUM_PINS+DATA_W-1)/DATA_W-1:0] irqBank
);
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int FIELDS    = DATA_W / 3;

  logic [NUM_PINS-1:0] bankMask, selBit;
  logic [NUM_PINS-1:0] outLatch, riseEn, fallEn, highEn, lowEn, status;
  logic [NUM_PINS-1:0] syncA, syncB, prevB, evNow;
  logic [2:0]          fselCode [NUM_PINS];
  logic [DATA_W-1:0]   rdWord;

  // Per-pin bank decode and function slot.
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic [2:0] code;
    assign bankMask[p] = (int'(strb.bank) == p / DATA_W);
    assign selBit[p]   = bankMask[p] & busWdata[p % DATA_W];
    always_ff @(posedge clk) begin
      if (!rstN) code <= 3'd0;
      else if (strb.fselWe && int'(strb.fselIdx) == p / FIELDS)
        code <= busWdata[(p % FIELDS)*3 +: 3];
    end
    assign fselCode[p] = code;
    assign pinOe[p]    = (code == FN_OUTPUT);
  end

  // Input synchronizer plus one cycle of history for edge finding.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevB <= '0;
    end else begin
      syncA <= pinIn; syncB <= syncA; prevB <= syncB;
    end
  end

  assign evNow = (riseEn & syncB & ~prevB) | (fallEn & ~syncB & prevB)
               | (highEn & syncB) | (lowEn & ~syncB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0; riseEn <= '0; fallEn <= '0;
      highEn   <= '0; lowEn  <= '0; status <= '0;
    end else begin
      outLatch <= (outLatch | (strb.setWe ? selBit : '0))
                & ~(strb.clrWe ? selBit : '0);
      if (strb.riseWe) riseEn <= (riseEn & ~bankMask) | selBit;
      if (strb.fallWe) fallEn <= (fallEn & ~bankMask) | selBit;
      if (strb.highWe) highEn <= (highEn & ~bankMask) | selBit;
      if (strb.lowWe)  lowEn  <= (lowEn  & ~bankMask) | selBit;
      status <= (status & ~(strb.statWe ? selBit : '0)) | evNow;
    end
  end

  assign pinOut = outLatch;

  always_comb begin
    irqBank = '0;
    for (int p = 0; p < NUM_PINS; p++) irqBank[p / DATA_W] = irqBank[p / DATA_W] | status[p];
  end

  function automatic logic [DATA_W-1:0] pickBank(input logic [NUM_PINS-1:0] v, input logic b);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (p / DATA_W == int'(b)) w[p % DATA_W] = v[p];
    return w;
  endfunction

  always_comb begin
    rdWord = '0;
    case (strb.rdSel)
      RD_FSEL: begin
        for (int p = 0; p < NUM_PINS; p++)
          if (p / FIELDS == int'(strb.fselIdx)) rdWord[(p % FIELDS)*3 +: 3] = fselCode[p];
      end
      RD_LEVEL:  rdWord = pickBank(syncB,  strb.bank);
      RD_STATUS: rdWord = pickBank(status, strb.bank);
      RD_RISE:   rdWord = pickBank(riseEn, strb.bank);
      RD_FALL:   rdWord = pickBank(fallEn, strb.bank);
      RD_HIGH:   rdWord = pickBank(highEn, strb.bank);
      RD_LOW:    rdWord = pickBank(lowEn,  strb.bank);
      default:   rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else if (busRd) busRdData <= rdWord;
  end

  // Set word raises every selected latch on the next edge.
  assert_set_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWe |=> ((outLatch & $past(selBit)) == $past(selBit)));

  // Clear word lowers every selected latch on the next edge.
  assert_clr_drives_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWe |=> ((outLatch & $past(selBit)) == '0));

  // A status bit only turns on when a detector fired in the cycle before.
  assert_status_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fselWe |=> ((status & ~$past(status) & ~$past(evNow)) == '0));

  // A write of ones clears those bits unless an event arrived together.
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.statWe |=> ((status & $past(selBit) & ~$past(evNow)) == '0));

  // Bits beyond the last pin never read back as one.
  assert_pad_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && strb.bank && strb.rdSel != RD_FSEL && strb.rdSel != RD_NONE)
      |=> (busRdData[DATA_W-1:NUM_PINS-DATA_W] == '0));
endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busRd,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [(NUM_PINS+DATA_W-1)/DATA_W-1:0] irqBank
);
  strobe_t strb;

  gpio_evt_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWr(busWr), .strb(strb)
  );

  gpio_evt_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busRd(busRd),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqBank(irqBank)
  );

  // Write-only set and clear words read back as zero.
  assert_setclr_read_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busAddr[ADDR_W-1:2] == 7 || busAddr[ADDR_W-1:2] == 8 ||
               busAddr[ADDR_W-1:2] == 10 || busAddr[ADDR_W-1:2] == 11))
      |=> (busRdData == '0));
endmodule

// File: tb/tb_gpio_event_bank.sv
`timescale 1ns/1ps
module tb_gpio_event_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdData;
  logic [53:0] pinIn = '0;
  logic [53:0] pinOut, pinOe;
  logic [1:0]  irqBank;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  gpio_event_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRd(busRd), .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqBank(irqBank)
  );

  typedef struct packed {
    logic        isWr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Walked in order from the reset state.
  localparam vec_t VEC [15] = '{
    '{1'b1, 8'h00, 32'h0000_000C, 32'h0,          8'd1},  // R1 pin0 code4, pin1 code1
    '{1'b0, 8'h00, 32'h0,          32'h0000_000C, 8'd1},  // R1
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0,          8'd11},
    '{1'b0, 8'h14, 32'h0,          32'h0000_0FFF, 8'd11}, // R11 only pins 50..53
    '{1'b1, 8'h1C, 32'h0000_00F0, 32'h0,          8'd2},  // R2
    '{1'b0, 8'h1C, 32'h0,          32'h0,          8'd11}, // R11
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0,          8'd2},
    '{1'b1, 8'h28, 32'h0000_0030, 32'h0,          8'd3},  // R3
    '{1'b1, 8'h4C, 32'h0000_0001, 32'h0,          8'd5},
    '{1'b0, 8'h4C, 32'h0,          32'h0000_0001, 8'd5},
    '{1'b1, 8'h50, 32'hFFFF_FFFF, 32'h0,          8'd11},
    '{1'b0, 8'h50, 32'h0,          32'h003F_FFFF, 8'd11},
    '{1'b1, 8'h50, 32'h0,          32'h0,          8'd11},
    '{1'b0, 8'h2C, 32'h0,          32'h0,          8'd11},
    '{1'b0, 8'h18, 32'h0,          32'h0,          8'd11}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; d = busRdData;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);

    // R10 reset state
    check("R10 pinOut", 64'(pinOut), 64'h0);
    check("R10 pinOe", 64'(pinOe), 64'h0);
    check("R10 irq", 64'(irqBank), 64'h0);
    busRead(8'h00, rd); check("R10 fsel", 64'(rd), 64'h0);
    busRead(8'h4C, rd); check("R10 rise enable", 64'(rd), 64'h0);
    busRead(8'h74, rd); check("R10 low enable", 64'(rd), 64'h0);

    for (int i = 0; i < 15; i++) begin
      if (VEC[i].isWr) busWrite(VEC[i].addr, VEC[i].data);
      else begin
        busRead(VEC[i].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(rd), 64'(VEC[i].exp));
      end
    end

    // R2 R3 latch result: pins 6,7 and 32..53 high
    check("R2 R3 pinOut", 64'(pinOut), 64'h003F_FFFF_0000_00C0);
    // R1 only pin1 has code 1
    check("R1 pinOe", 64'(pinOe), 64'h2);

    // R4 synchronized level
    pinIn[40] = 1'b1;
    waitCycles(3);
    busRead(8'h38, rd); check("R4 level bank1", 64'(rd), 64'h100);
    busRead(8'h34, rd); check("R4 level bank0", 64'(rd), 64'h0);
    pinIn[40] = 1'b0;

    // R5 rising edge on pin0
    pinIn[0] = 1'b1;
    waitCycles(4);
    busRead(8'h40, rd); check("R5 rise status", 64'(rd), 64'h1);
    check("R9 irq bank0", 64'(irqBank), 64'h1);
    busWrite(8'h40, 32'h0);
    busRead(8'h40, rd); check("R8 zero write ignored", 64'(rd), 64'h1);
    busWrite(8'h40, 32'h1);
    busRead(8'h40, rd); check("R8 cleared", 64'(rd), 64'h0);
    check("R9 irq low", 64'(irqBank), 64'h0);

    // R6 both edges on pin0
    busWrite(8'h58, 32'h1);
    pinIn[0] = 1'b0;
    waitCycles(4);
    busRead(8'h40, rd); check("R6 falling", 64'(rd), 64'h1);
    busWrite(8'h40, 32'h1);
    pinIn[0] = 1'b1;
    waitCycles(4);
    busRead(8'h40, rd); check("R6 rising with both", 64'(rd), 64'h1);
    busWrite(8'h40, 32'h1);
    busWrite(8'h4C, 32'h0);
    pinIn[0] = 1'b0;
    waitCycles(4);
    busWrite(8'h40, 32'h1);
    pinIn[0] = 1'b1;
    waitCycles(4);
    busRead(8'h40, rd); check("R5 rise disabled", 64'(rd), 64'h0);

    // R7 high level on pin33
    busWrite(8'h68, 32'h2);
    pinIn[33] = 1'b1;
    waitCycles(4);
    busRead(8'h44, rd); check("R7 high level", 64'(rd), 64'h2);
    check("R9 irq bank1 only", 64'(irqBank), 64'h2);
    busWrite(8'h44, 32'h2);
    busRead(8'h44, rd); check("R7 R8 reappears", 64'(rd), 64'h2);
    pinIn[33] = 1'b0;
    waitCycles(4);
    busWrite(8'h44, 32'h2);
    busRead(8'h44, rd); check("R7 gone after level drop", 64'(rd), 64'h0);

    // R7 low level on pin33
    busWrite(8'h74, 32'h2);
    waitCycles(2);
    busRead(8'h44, rd); check("R7 low level", 64'(rd), 64'h2);
    busWrite(8'h74, 32'h0);
    busWrite(8'h44, 32'h2);
    busRead(8'h44, rd); check("R7 low disabled", 64'(rd), 64'h0);
    check("R9 irq idle", 64'(irqBank), 64'h0);

    finishRun();
  end
endmodule